// File: doc/BRIEF.md
# Aging-Counter Replacement Victim Selector

This block keeps a short history of page use for a fixed set of physical frames and names a frame to evict when asked. Each frame owns an 8-bit history register and a one-bit "used" flag. The flag is set whenever a reference notification names that frame. At every periodic tick, each history register moves one place toward its least significant end. The frame's used flag fills the vacated top bit, and the flag is then cleared for the next interval. A reference in the most recent interval therefore always weighs more than any mix of older references.

When a page is placed in a frame, that frame's history starts again from zero with its used flag set. A victim query returns, one clock later, the index of the frame whose history value is numerically smallest. Equal values resolve to the lowest index. The same response also carries that smallest history value. Policy decisions above this, such as what to do with the chosen frame, are left to the surrounding logic.

Top module: `aging_victim_sel`

## Requirements
- R1: While rst_n is low at a clock edge, every history register and used flag is cleared, and victim_valid is low in the following cycle.
- R2: On a clock edge with tick high and no load for a frame, that frame's history becomes {used flag, history[7:1]}: the used flag is the new bit 7, and old bit 0 is dropped.
- R3: On a tick edge each used flag takes the value of that frame's same-cycle reference (hit_valid high and hit_frame equal to the frame's binary index). A reference coinciding with a tick therefore counts in the new interval and is not lost.
- R4: A frame referenced only in the latest completed interval (history 8'h80) outranks a frame referenced in every one of the seven intervals before it (history 8'h7F), so the latter is chosen as victim.
- R5: The victim is the frame with the numerically smallest history. Among equal values the lowest frame index is chosen. victim_frame is the binary frame index.
- R6: victim_valid is high exactly in the cycle after query is high. victim_frame and victim_age reflect the history values held during the query cycle, before any tick, load or reference taken at that same edge.
- R7: A load (load_valid high, load_frame equal to the index) clears that frame's history and sets its used flag at the edge. For that frame, a load wins over a tick and over a reference in the same cycle.
- R8: Between ticks a used flag stays set once set; repeated references to the same frame have the same effect as one.
- R9: victim_age carries the smallest history value, the value held by the frame named in victim_frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hit_valid | input | 1 | Reference notification strobe |
| hit_frame | input | 3 | Frame index being referenced |
| tick | input | 1 | Periodic aging strobe |
| load_valid | input | 1 | New page placed in a frame |
| load_frame | input | 3 | Frame index being loaded |
| query | input | 1 | Victim request |
| victim_valid | output | 1 | Victim response is valid |
| victim_frame | output | 3 | Index of chosen frame |
| victim_age | output | 8 | History value of chosen frame |

## Verification
Every history and used-flag update lands at the clock edge that captures its reference, tick or load. A victim response is due exactly one cycle after its query, and it is computed from the history held before that edge. The bench drives stimulus half a cycle ahead of each edge and updates its own model of the histories at the same step. When a query is issued, the bench pushes the model's answer into a queue, and the monitor pops it two nanoseconds after the next rising edge. A response that is missing or unexpected in that cycle is reported. Directed sequences put ticks, loads and references in the same cycle as each other and as queries, so the ordering rules are checked where they matter.

// File: rtl/aging_pkg.sv
// Package: shared defaults for the aging victim selector.
// Assumes: consumers derive index widths from the frame count.
package aging_pkg;
    localparam int DEF_FRAMES = 8;
    localparam int DEF_AGE_W  = 8;
endpackage

// File: rtl/aging_frame_cell.sv
// Module: aging_frame_cell
// Holds one frame's history register and used flag. A load resets the
// history and marks the frame used; a tick shifts the used flag into the
// top of the history and restarts the flag from the same-cycle reference.
// Assumes: at most one of load/tick precedence rules applies, load first.
module aging_frame_cell #(
    parameter int AGE_W = aging_pkg::DEF_AGE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hit,
    input  logic             load,
    output logic [AGE_W-1:0] age_o,
    output logic             used_o
);

    // History and used-flag update for this frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_o  <= '0;
            used_o <= 1'b0;
        end else if (load) begin
            age_o  <= '0;
            used_o <= 1'b1;
        end else if (tick) begin
            age_o  <= {used_o, age_o[AGE_W-1:1]};
            used_o <= hit;
        end else if (hit) begin
            used_o <= 1'b1;
        end
    end

    AST_TICK_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> (age_o[AGE_W-2:0] == $past(age_o[AGE_W-1:1]))); // R2
    AST_TICK_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> (age_o[AGE_W-1] == $past(used_o))); // R2
    AST_TICK_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> (used_o == $past(hit))); // R3
    AST_LOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (age_o == '0 && used_o)); // R7
    AST_USED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load && used_o) |=> used_o); // R8

endmodule

// File: rtl/aging_min_tree.sv
// Module: aging_min_tree
// Combinational tournament that finds the smallest history value and its
// frame index. Leaves are padded to a power of two with all-ones values
// so padding never wins. The left operand wins on equality, which with
// leaves in index order picks the lowest index.
// Assumes: NUM >= 2.
module aging_min_tree #(
    parameter int NUM   = aging_pkg::DEF_FRAMES,
    parameter int AGE_W = aging_pkg::DEF_AGE_W,
    parameter int IDX_W = $clog2(NUM)
) (
    input  logic [NUM-1:0][AGE_W-1:0] ages_i,
    output logic [IDX_W-1:0]          idx_o,
    output logic [AGE_W-1:0]          age_o
);

    localparam int LEAVES = 1 << IDX_W;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [AGE_W-1:0] node_age [NODES];
    logic [IDX_W-1:0] node_idx [NODES];

    // Leaf layer: real frames, then padding that can never be smallest
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NUM) begin : g_real
            assign node_age[LEAVES-1+i] = ages_i[i];
        end else begin : g_pad
            assign node_age[LEAVES-1+i] = '1;
        end
        assign node_idx[LEAVES-1+i] = IDX_W'(i);
    end

    // Inner nodes: keep the left child unless the right is strictly smaller
    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        logic take_right;
        assign take_right  = node_age[2*k+2] < node_age[2*k+1];
        assign node_age[k] = take_right ? node_age[2*k+2] : node_age[2*k+1];
        assign node_idx[k] = take_right ? node_idx[2*k+2] : node_idx[2*k+1];
    end

    assign idx_o = node_idx[0];
    assign age_o = node_age[0];

endmodule

// File: rtl/aging_victim_sel.sv
// Module: aging_victim_sel (top)
// Approximates least-recently-used replacement with per-frame aging
// histories. Decodes reference and load strobes to frames, ages all frames
// on a tick and registers the smallest-history frame one cycle after a query.
// Assumes: synchronous active-low reset; frame indices below NUM_FRAMES.
module aging_victim_sel #(
    parameter int NUM_FRAMES = aging_pkg::DEF_FRAMES,
    parameter int AGE_W      = aging_pkg::DEF_AGE_W,
    localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_valid,
    input  logic [IDX_W-1:0] hit_frame,
    input  logic             tick,
    input  logic             load_valid,
    input  logic [IDX_W-1:0] load_frame,
    input  logic             query,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_frame,
    output logic [AGE_W-1:0] victim_age
);

    logic [NUM_FRAMES-1:0]            hit_vec;
    logic [NUM_FRAMES-1:0]            load_vec;
    logic [NUM_FRAMES-1:0][AGE_W-1:0] ages;
    logic [NUM_FRAMES-1:0]            used;
    logic [IDX_W-1:0]                 min_idx;
    logic [AGE_W-1:0]                 min_age;

    // Per-frame cells with decoded strobes
    for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
        assign hit_vec[f]  = hit_valid  && (hit_frame  == IDX_W'(f));
        assign load_vec[f] = load_valid && (load_frame == IDX_W'(f));

        aging_frame_cell #(.AGE_W(AGE_W)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .hit    (hit_vec[f]),
            .load   (load_vec[f]),
            .age_o  (ages[f]),
            .used_o (used[f])
        );

        AST_VICTIM_MIN: assert property (@(posedge clk) disable iff (!rst_n)
            query |=> (victim_age <= $past(ages[f]))); // R5
    end

    aging_min_tree #(
        .NUM   (NUM_FRAMES),
        .AGE_W (AGE_W),
        .IDX_W (IDX_W)
    ) u_tree (
        .ages_i (ages),
        .idx_o  (min_idx),
        .age_o  (min_age)
    );

    // Register the victim response one cycle after the query
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_valid <= 1'b0;
            victim_frame <= '0;
            victim_age   <= '0;
        end else begin
            victim_valid <= query;
            if (query) begin
                victim_frame <= min_idx;
                victim_age   <= min_age;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !victim_valid); // R1
    AST_VICTIM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        query |=> victim_valid); // R6
    AST_VICTIM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !query |=> !victim_valid); // R6
    AST_VICTIM_AGE: assert property (@(posedge clk) disable iff (!rst_n)
        query |=> (victim_age == $past(ages[min_idx]))); // R9

endmodule

// File: tb/aging_victim_sel_test.sv
// Bench: scoreboard for aging_victim_sel. A driver task applies one cycle
// of stimulus, updates a reference model and queues the expected victim;
// a monitor pops and compares two nanoseconds after each rising edge.
module aging_victim_sel_test;

    localparam int N = 8;
    localparam int W = 8;

    typedef struct {
        int    frame;
        int    age;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hit_valid = 1'b0;
    logic [2:0] hit_frame = '0;
    logic       tick = 1'b0;
    logic       load_valid = 1'b0;
    logic [2:0] load_frame = '0;
    logic       query = 1'b0;
    logic       victim_valid;
    logic [2:0] victim_frame;
    logic [7:0] victim_age;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t expq[$];
    int   m_age [N];
    bit   m_used[N];

    aging_victim_sel uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_valid    (hit_valid),
        .hit_frame    (hit_frame),
        .tick         (tick),
        .load_valid   (load_valid),
        .load_frame   (load_frame),
        .query        (query),
        .victim_valid (victim_valid),
        .victim_frame (victim_frame),
        .victim_age   (victim_age)
    );

    always #4 clk = ~clk;

    // One cycle of stimulus; model answer queued on query, then model update
    task automatic step(input bit rv, input int rf, input bit tk,
                        input bit lv, input int lf, input bit q, input string tag);
        exp_t e;
        hit_valid  = rv;
        hit_frame  = 3'(rf);
        tick       = tk;
        load_valid = lv;
        load_frame = 3'(lf);
        query      = q;
        if (q) begin
            e.frame = 0;
            e.age   = m_age[0];
            for (int i = 1; i < N; i++)
                if (m_age[i] < e.age) begin
                    e.age   = m_age[i];
                    e.frame = i;
                end
            e.tag = tag;
            expq.push_back(e);
        end
        for (int i = 0; i < N; i++) begin
            bit h;
            h = rv && (rf == i);
            if (lv && (lf == i)) begin
                m_age[i]  = 0;
                m_used[i] = 1'b1;
            end else if (tk) begin
                m_age[i]  = (int'(m_used[i]) << (W - 1)) | (m_age[i] >> 1);
                m_used[i] = h;
            end else if (h) begin
                m_used[i] = 1'b1;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic ask(input string tag);
        step(0, 0, 0, 0, 0, 1, tag);
    endtask

    // Monitor: compare each response in the cycle it is due
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            if (victim_valid) begin
                checks++;
                if (expq.size() == 0) begin
                    fails++;
                    $display("FAIL R6: unexpected victim_valid, actual 1 expected 0");
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (int'(victim_frame) != e.frame || int'(victim_age) != e.age) begin
                        fails++;
                        $display("FAIL %s: victim frame/age actual %0d/%0h expected %0d/%0h",
                                 e.tag, victim_frame, victim_age, e.frame, e.age);
                    end
                end
            end else if (expq.size() != 0) begin
                exp_t e;
                e = expq.pop_front();
                checks++;
                fails++;
                $display("FAIL R6 (%s): victim_valid actual 0 expected 1", e.tag);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        int lfsr;
        for (int i = 0; i < N; i++) begin
            m_age[i]  = 0;
            m_used[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        checks++;
        if (victim_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: victim_valid in reset actual %b expected 0", victim_valid);
        end
        rst_n = 1'b1;

        // R1: cleared state gives frame 0 with zero history
        ask("R1");
        idle();

        // R5 tie: reference frames 0 and 1, tick, lowest remaining zero wins
        step(1, 0, 0, 0, 0, 0, "");
        step(1, 1, 0, 0, 0, 0, "");
        step(0, 0, 1, 0, 0, 0, "");
        ask("R5 tie lowest index");
        idle();

        // R2: fade all to zero via loads then nine ticks
        for (int f = 0; f < N; f++) step(0, 0, 0, 1, f, 0, "");
        for (int t = 0; t < 9; t++) step(0, 0, 1, 0, 0, 0, "");
        ask("R2 faded history");

        // R4: seven intervals referencing all but frame 5
        for (int t = 0; t < 7; t++) begin
            for (int f = 0; f < N; f++)
                if (f != 5) step(1, f, 0, 0, 0, 0, "");
            step(0, 0, 1, 0, 0, 0, "");
        end
        for (int f = 0; f < N; f++)
            if (f != 2) step(1, f, 0, 0, 0, 0, "");
        step(0, 0, 1, 0, 0, 0, "");
        ask("R4 recent outranks older");
        idle();

        // R3: reference in the tick cycle counts in the new interval
        step(1, 2, 1, 0, 0, 0, "");
        step(0, 0, 1, 0, 0, 0, "");
        ask("R3 ref with tick");

        // R7: load beats tick and reference for the same frame
        step(1, 6, 1, 1, 6, 0, "");
        ask("R7 load with tick");
        step(0, 0, 1, 0, 0, 0, "");
        ask("R7 loaded frame aged");

        // R6: query in a tick cycle sees pre-tick histories
        step(0, 0, 1, 0, 0, 1, "R6 query with tick");
        ask("R6 after tick");
        step(0, 0, 0, 0, 0, 1, "R9 back-to-back query");
        idle();

        // R8: repeated references equal one
        step(1, 4, 0, 0, 0, 0, "");
        step(1, 4, 0, 0, 0, 0, "");
        step(1, 4, 0, 0, 0, 0, "");
        step(0, 0, 1, 0, 0, 0, "");
        ask("R8 sticky flag");
        idle();

        // R5/R9: pseudo-random mix with a query every cycle
        lfsr = 16'hACE1;
        for (int c = 0; c < 3000; c++) begin
            lfsr = ((lfsr >> 1) | (((lfsr ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
            step(lfsr[0], (lfsr >> 1) & 7, ((lfsr >> 4) & 7) == 0,
                 ((lfsr >> 7) & 15) == 0, (lfsr >> 11) & 7, lfsr[14] | lfsr[15],
                 "R5 mixed traffic");
        end
        idle();
        idle();

        // R1: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (victim_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: victim_valid after reset actual %b expected 0", victim_valid);
        end
        for (int i = 0; i < N; i++) begin
            m_age[i]  = 0;
            m_used[i] = 1'b0;
        end
        rst_n = 1'b1;
        step(0, 0, 1, 0, 0, 0, "");
        ask("R1 cleared flags after reset");
        idle();
        idle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule